// File: doc/BRIEF.md
# Tracking ADC Step Controller

This block is the digital core of a continuous tracking analog-to-digital converter. An external windowed comparator compares the analog input with the output of a resistor-ladder DAC. It reports "step up" when the ladder sits more than half an LSB below the input, and "step down" when the ladder sits more than half an LSB above it. The controller registers these indications into request flops. It then uses an interlock to turn a single pending request into a one-step count enable. The result moves an N-bit code by one position. The code drives the ladder and is also the conversion result.

A request is captured on one rising edge and consumed on the next. On that next edge the counter steps and the request is cleared. The following edge samples the comparator again, so it sees the ladder after the step has taken effect. The loop therefore never overshoots. Inside the dead band neither indication is present, so the code stays at the value that lies within half an LSB of the input, with no dithering. The counter saturates at both ends, and a status flag reports when the comparator was quiet on the previous edge.

Top module: `trk_adc_ctrl`

## Requirements
- R1: An indication sampled high on a rising edge moves the code by exactly one step on the next rising edge. The edge that performs the step samples no new request, so a held indication steps the code once every two clock periods.
- R2: A captured request is always cleared on the edge after it is captured, so the code changes by at most one step per clock period.
- R3: When both indications are captured together, no count enable is produced and the code keeps its value.
- R4: A captured up request alone increments the code by one. A captured down request alone decrements it by one.
- R5: With a static input, the loop settles to the code whose ladder level is within half an LSB of the input, and the code stays constant from then on.
- R6: The code saturates instead of wrapping. A down step at code 0 and an up step at the all-ones code leave the code unchanged.
- R7: `settled_o` is high in the cycle after a rising edge at which both indications were low, and low in the cycle after an edge at which either indication was high.
- R8: A synchronous reset clears the code to 0, clears both request flops and drives `settled_o` low.
- R9: While the input ramps slowly (one quarter LSB every 16 clocks), the ladder level stays within one LSB of the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising-edge active |
| srst_i | input | 1 | Synchronous reset, active high |
| cmp_up_i | input | 1 | Comparator: ladder more than half an LSB below the input |
| cmp_dn_i | input | 1 | Comparator: ladder more than half an LSB above the input |
| code_o | output | CODE_W | Ladder drive and conversion result |
| settled_o | output | 1 | Neither indication was high at the last edge |

## Verification
The assertions take no constraint from the comparator inputs, because the interlock has to hold even when both indications are high. They do assume a synchronous reset is applied before any check is armed. The bench comparator model derives both indications from the code itself, using quarter-LSB integer arithmetic with a half-LSB dead band, so they can never be high together. The only input pattern that breaks this is a directed case that forces both high on purpose to exercise the interlock. The static input levels are chosen away from the exact half-LSB boundary, so each one has a single settled code.

// File: rtl/trk_adc_pkg.sv
package trk_adc_pkg;
   typedef enum logic [1:0] {
      STEP_HOLD = 2'b00,
      STEP_INC  = 2'b01,
      STEP_DEC  = 2'b10
   } step_e;
endpackage

// File: rtl/trk_req_latch.sv
module trk_req_latch (
   input  logic clk_i,
   input  logic srst_i,
   input  logic up_i,
   input  logic dn_i,
   output logic req_up_o,
   output logic req_dn_o
);
   logic up_q, dn_q, consume;

   assign consume = up_q | dn_q;

   always_ff @(posedge clk_i) begin
      if (srst_i || consume) begin
         up_q <= 1'b0;
         dn_q <= 1'b0;
      end else begin
         up_q <= up_i;
         dn_q <= dn_i;
      end
   end

   assign req_up_o = up_q;
   assign req_dn_o = dn_q;
endmodule

// File: rtl/trk_step_gate.sv
module trk_step_gate
   import trk_adc_pkg::*;
(
   input  logic  req_up_i,
   input  logic  req_dn_i,
   input  logic  at_max_i,
   input  logic  at_min_i,
   output step_e step_o
);
   logic inc_ok, dec_ok;

   assign inc_ok = req_up_i & ~req_dn_i & ~at_max_i;
   assign dec_ok = req_dn_i & ~req_up_i & ~at_min_i;

   always_comb begin
      step_o = STEP_HOLD;
      if (inc_ok)      step_o = STEP_INC;
      else if (dec_ok) step_o = STEP_DEC;
   end
endmodule

// File: rtl/trk_code_ctr.sv
module trk_code_ctr
   import trk_adc_pkg::*;
#(
   parameter int CODE_W = 8
) (
   input  logic              clk_i,
   input  logic              srst_i,
   input  step_e             step_i,
   output logic [CODE_W-1:0] code_o,
   output logic              at_max_o,
   output logic              at_min_o
);
   localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};
   localparam logic [CODE_W-1:0] CODE_MIN = '0;
   localparam logic [CODE_W-1:0] ONE      = CODE_W'(1);

   logic [CODE_W-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (srst_i) begin
         cnt_q <= CODE_MIN;
      end else begin
         unique case (step_i)
            STEP_INC: cnt_q <= cnt_q + ONE;
            STEP_DEC: cnt_q <= cnt_q - ONE;
            default:  cnt_q <= cnt_q;
         endcase
      end
   end

   assign code_o   = cnt_q;
   assign at_max_o = (cnt_q == CODE_MAX);
   assign at_min_o = (cnt_q == CODE_MIN);
endmodule

// File: rtl/trk_settle_flag.sv
module trk_settle_flag (
   input  logic clk_i,
   input  logic srst_i,
   input  logic up_i,
   input  logic dn_i,
   output logic settled_o
);
   logic quiet_q;

   always_ff @(posedge clk_i) begin
      if (srst_i) quiet_q <= 1'b0;
      else        quiet_q <= ~(up_i | dn_i);
   end

   assign settled_o = quiet_q;
endmodule

// File: rtl/trk_adc_ctrl.sv
module trk_adc_ctrl
   import trk_adc_pkg::*;
#(
   parameter int CODE_W = 8
) (
   input  logic              clk_i,
   input  logic              srst_i,
   input  logic              cmp_up_i,
   input  logic              cmp_dn_i,
   output logic [CODE_W-1:0] code_o,
   output logic              settled_o
);
   if (CODE_W < 2 || CODE_W > 24) begin : g_bad_width
      $error("trk_adc_ctrl: CODE_W must lie in 2..24");
   end

   logic  req_up, req_dn, at_max, at_min;
   step_e step;

   trk_req_latch u_req (
      .clk_i    (clk_i),
      .srst_i   (srst_i),
      .up_i     (cmp_up_i),
      .dn_i     (cmp_dn_i),
      .req_up_o (req_up),
      .req_dn_o (req_dn)
   );

   trk_step_gate u_gate (
      .req_up_i (req_up),
      .req_dn_i (req_dn),
      .at_max_i (at_max),
      .at_min_i (at_min),
      .step_o   (step)
   );

   trk_code_ctr #(.CODE_W(CODE_W)) u_ctr (
      .clk_i    (clk_i),
      .srst_i   (srst_i),
      .step_i   (step),
      .code_o   (code_o),
      .at_max_o (at_max),
      .at_min_o (at_min)
   );

   trk_settle_flag u_settle (
      .clk_i     (clk_i),
      .srst_i    (srst_i),
      .up_i      (cmp_up_i),
      .dn_i      (cmp_dn_i),
      .settled_o (settled_o)
   );
endmodule

// File: rtl/trk_adc_ctrl_chk.sv
module trk_adc_ctrl_chk #(
   parameter int CODE_W = 8
) (
   input logic              clk_i,
   input logic              srst_i,
   input logic              cmp_up_i,
   input logic              cmp_dn_i,
   input logic [CODE_W-1:0] code_i,
   input logic              settled_i,
   input logic              req_up_i,
   input logic              req_dn_i
);
   localparam logic [CODE_W-1:0] MAXC = {CODE_W{1'b1}};
   localparam logic [CODE_W-1:0] ONE  = CODE_W'(1);

   logic armed_q = 1'b0;
   always_ff @(posedge clk_i) begin
      if (srst_i) armed_q <= 1'b1;
   end

   // R2
   req_clear_chk: assert property (@(posedge clk_i) disable iff (srst_i || !armed_q)
      (req_up_i || req_dn_i) |=> !(req_up_i || req_dn_i));

   // R2
   single_step_chk: assert property (@(posedge clk_i) disable iff (srst_i || !armed_q)
      1'b1 |=> (code_i == $past(code_i) || code_i == $past(code_i) + ONE
                || code_i == $past(code_i) - ONE));

   // R3
   interlock_hold_chk: assert property (@(posedge clk_i) disable iff (srst_i || !armed_q)
      (req_up_i && req_dn_i) |=> $stable(code_i));

   // R4
   inc_step_chk: assert property (@(posedge clk_i) disable iff (srst_i || !armed_q)
      (req_up_i && !req_dn_i && code_i != MAXC) |=> code_i == $past(code_i) + ONE);

   // R4
   dec_step_chk: assert property (@(posedge clk_i) disable iff (srst_i || !armed_q)
      (req_dn_i && !req_up_i && code_i != '0) |=> code_i == $past(code_i) - ONE);

   // R6
   no_wrap_high_chk: assert property (@(posedge clk_i) disable iff (srst_i || !armed_q)
      (code_i == MAXC) |=> code_i != '0);

   // R6
   no_wrap_low_chk: assert property (@(posedge clk_i) disable iff (srst_i || !armed_q)
      (code_i == '0) |=> code_i != MAXC);

   // R7
   settle_flag_chk: assert property (@(posedge clk_i) disable iff (srst_i || !armed_q)
      1'b1 |=> settled_i == !($past(cmp_up_i) || $past(cmp_dn_i)));

   // R8
   reset_state_chk: assert property (@(posedge clk_i)
      srst_i |=> (code_i == '0 && !settled_i && !req_up_i && !req_dn_i));
endmodule

bind trk_adc_ctrl trk_adc_ctrl_chk #(.CODE_W(CODE_W)) chk_i (
   .clk_i     (clk_i),
   .srst_i    (srst_i),
   .cmp_up_i  (cmp_up_i),
   .cmp_dn_i  (cmp_dn_i),
   .code_i    (code_o),
   .settled_i (settled_o),
   .req_up_i  (req_up),
   .req_dn_i  (req_dn)
);

// File: tb/trk_adc_ctrl_tb_top.sv
`timescale 1ns/1ps
module trk_adc_ctrl_tb_top;
   localparam int CODE_W = 8;
   localparam int MAXV   = (1 << CODE_W) - 1;

   logic clk = 1'b0;
   logic srst = 1'b1;
   logic use_model = 1'b0;
   logic man_up = 1'b0, man_dn = 1'b0;
   int   vq = 0;
   int   lad;
   logic mdl_up, mdl_dn, up, dn;
   logic [CODE_W-1:0] code;
   logic settled;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   // comparator model: quarter-LSB units, half-LSB dead band
   always_comb begin
      lad    = 4 * int'(code);
      mdl_up = (vq - lad) > 2;
      mdl_dn = (lad - vq) > 2;
   end
   assign up = use_model ? mdl_up : man_up;
   assign dn = use_model ? mdl_dn : man_dn;

   trk_adc_ctrl #(.CODE_W(CODE_W)) dut_i (
      .clk_i (clk), .srst_i (srst), .cmp_up_i (up), .cmp_dn_i (dn),
      .code_o (code), .settled_o (settled)
   );

   localparam int VEC_N = 9;
   localparam int VEC_VQ [VEC_N] = '{200, 41, 1020, 1100, 517, 3, 1022, 0, 599};
   localparam int VEC_EXP[VEC_N] = '{ 50, 10,  255,  255, 129, 1,  255, 0, 150};
   localparam bit VEC_SET[VEC_N] = '{  1,  1,    1,    0,   1, 1,    1, 1,   1};

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int base;
      int ramp_bad;
      tick(3);
      // R8 reset state
      chk("R8 code after reset", int'(code), 0);
      chk("R8 settled after reset", int'(settled), 0);
      srst = 1'b0;
      tick(1);
      chk("R7 quiet inputs set settled", int'(settled), 1);

      // R1 single pulse: step on second edge only
      man_up = 1'b1;
      tick(1);
      man_up = 1'b0;
      chk("R1 no step on capture edge", int'(code), 0);
      chk("R7 settled drops after indication", int'(settled), 0);
      tick(1);
      chk("R1 step on next edge", int'(code), 1);
      tick(4);
      chk("R2 single step only", int'(code), 1);

      // R1 held indication: one step per two clocks
      man_up = 1'b1;
      tick(10);
      man_up = 1'b0;
      tick(2);
      chk("R1 held up ten edges", int'(code), 6);

      // R4 down steps
      man_dn = 1'b1;
      tick(4);
      man_dn = 1'b0;
      tick(2);
      chk("R4 down steps", int'(code), 4);

      // R3 both indications
      man_up = 1'b1; man_dn = 1'b1;
      tick(8);
      man_up = 1'b0; man_dn = 1'b0;
      tick(2);
      chk("R3 both held no change", int'(code), 4);

      // R6 floor saturation
      man_dn = 1'b1;
      tick(20);
      man_dn = 1'b0;
      tick(2);
      chk("R6 hold at zero", int'(code), 0);

      // R5 table walk with the comparator model
      use_model = 1'b1;
      for (int i = 0; i < VEC_N; i++) begin
         vq = VEC_VQ[i];
         tick(600);
         chk("R5 settled code", int'(code), VEC_EXP[i]);
         chk("R7 settled flag", int'(settled), int'(VEC_SET[i]));
         base = int'(code);
         tick(40);
         chk("R5 no oscillation", int'(code), base);
      end

      // R9 slow ramp
      ramp_bad = 0;
      for (int s = 0; s < 400; s++) begin
         vq = 600 + s;
         for (int c = 0; c < 16; c++) begin
            tick(1);
            if ((4 * int'(code) - vq) > 4 || (vq - 4 * int'(code)) > 4) ramp_bad++;
         end
      end
      chk("R9 ramp tracking violations", ramp_bad, 0);

      // R6 ceiling saturation with forced up
      use_model = 1'b0;
      man_up = 1'b1;
      tick(400);
      chk("R6 hold at max", int'(code), MAXV);
      man_up = 1'b0;

      // R8 mid-run reset
      srst = 1'b1;
      tick(2);
      chk("R8 code after mid-run reset", int'(code), 0);
      chk("R8 settled after mid-run reset", int'(settled), 0);
      srst = 1'b0;
      tick(2);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule